// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Timer

This block turns a raw, active-low overcurrent indication into a hiccup-mode protection output. When a fault is seen while the block is idle, a disconnect flag goes high for a fixed off period so the load switch opens. The flag then drops for a forced on period of the same length, so the load is powered again. Only after both periods have run out does the block look at the fault line again. A fault that is still present at that point starts the next off period at once.

The fault line is asynchronous, so it passes through a two-flop synchronizer first. All timing comes from one down counter of `CNT_W` bits. A start from zero wraps the counter to all ones, and its top bit drives the disconnect flag directly. The counter counts down through both halves of the cycle and stops at zero. The zero state is detected by the borrow out of the decrement, so no separate compare against zero is needed. Each half lasts 2^(CNT_W-1) clocks, so `CNT_W` is set to give about one second per half at the chosen clock. An optional busy output is high while a cycle is in progress.

Top module: `hiccup_timer`

## Requirements
- R1: `fault_n` is active low: a 0 means an overcurrent is present and a 1 means no fault. With `fault_n` held at 1, no cycle ever starts.
- R2: If `fault_n` is 0 at rising edge k while the block is idle, `flag` and `busy` both go to 1 after rising edge k+2. The two extra edges come from the two-flop synchronizer. A fault that lasts one clock is enough to start a cycle.
- R3: Once raised, `flag` stays at 1 for exactly 2^(CNT_W-1) clock cycles.
- R4: After the off period, `flag` is 0 and `busy` stays at 1 for exactly 2^(CNT_W-1)-1 further cycles. `busy` then goes to 0.
- R5: While `busy` is 1, `fault_n` has no effect. Fault pulses during a cycle change neither the length of either period nor the number of times `flag` rises.
- R6: While idle with `fault_n` at 1, `flag` and `busy` stay at 0.
- R7: If the fault is still present when a cycle ends, `busy` is 0 for exactly one cycle. After that one cycle, `flag` and `busy` rise again and a new cycle starts.
- R8: A synchronous active-high `rst` clears the block to idle at the next rising edge, even in the middle of a cycle, with `flag` and `busy` both at 0. The synchronizer is cleared to the no-fault state.
- R9: `flag` is never 1 while `busy` is 0 (with `BUSY_EN` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_n | input | 1 | Raw asynchronous overcurrent line, 0 = fault |
| flag | output | 1 | Disconnect request, 1 = load off |
| busy | output | 1 | High while a hiccup cycle is running (tied low if `BUSY_EN` = 0) |

## Verification
The assertions assume that `rst` is driven high from time zero and is held for at least one edge. They also take `clk` as free-running. The properties are written only in terms of the counter state and the outputs, so they make no assumption about the shape of `fault_n`. The stimulus drives every input on the falling edge, which keeps `fault_n` and `rst` stable around each rising edge. Apart from the retrigger test, the stimulus releases each fault well before the cycle ends, so each measured window contains exactly one cycle.

// File: rtl/hic_pkg.sv
package hic_pkg;

    // Output pair of the timer
    typedef struct packed {
        logic flag;
        logic busy;
    } hic_status_t;

    // Clock cycles in each half of a hiccup cycle
    function automatic int unsigned half_len(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/hic_sync.sv
module hic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic fault_seen
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_n};
        end
    end

    assign fault_seen = ~chain_q[STAGES-1];
endmodule

// File: rtl/hic_down_counter.sv
module hic_down_counter #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic [W-1:0] cnt_q
);
    logic [W:0] dec_ext;
    logic       at_zero;

    // The borrow out of the decrement marks the zero state
    assign dec_ext = {1'b0, cnt_q} - {{W{1'b0}}, 1'b1};
    assign at_zero = dec_ext[W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!at_zero || start) begin
            cnt_q <= dec_ext[W-1:0];
        end
    end

    // R6: the zero state holds without a start request
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !start) |=> (cnt_q == '0));

    // R2: a start from zero wraps to all ones
    assert_wrap_start_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && start) |=> (cnt_q == '1));

    // R5: once running, the count steps down whatever start does
    assert_ignore_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
    parameter int CNT_W   = 21,
    parameter bit BUSY_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_n,
    output logic flag,
    output logic busy
);
    import hic_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic             fault_seen;
    logic [CNT_W-1:0] cnt;
    hic_status_t      stat;

    hic_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_n    (fault_n),
        .fault_seen (fault_seen)
    );

    hic_down_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .start (fault_seen),
        .cnt_q (cnt)
    );

    assign stat.flag = cnt[CNT_W-1];

    generate
        if (BUSY_EN) begin : g_busy
            assign stat.busy = |cnt;

            // R9: the flag only ever appears inside a busy cycle
            assert_flag_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
                flag |-> busy);

            // R2: the flag rises only from the idle state
            assert_rise_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(flag) |-> $past(!busy));

            // R4: a cycle ends out of the on period
            assert_end_after_on_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(busy) |-> $past(!flag));
        end else begin : g_nobusy
            assign stat.busy = 1'b0;
        end
    endgenerate

    assign flag = stat.flag;
    assign busy = stat.busy;

    // R8: reset leaves the block idle with the flag low
    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (!flag && !busy));
endmodule

// File: tb/hiccup_timer_bench.sv
module hiccup_timer_bench;
    localparam int W    = 6;
    localparam int HALF = 1 << (W - 1);
    localparam int WIN  = 2 * HALF + 20;
    localparam int NVEC = 6;

    // each entry: {fault pulse length in clocks, inject glitches during cycle}
    localparam int VEC_LEN [NVEC] = '{1, 2, 7, 20, 1, 3};
    localparam bit VEC_GL  [NVEC] = '{0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fault_n = 1'b1;
    logic flag, busy;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hiccup_timer #(.CNT_W(W), .BUSY_EN(1'b1)) u_hiccup_timer (
        .clk(clk), .rst(rst), .fault_n(fault_n), .flag(flag), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Starts a fault at a falling edge and records the cycle shape
    task automatic run_window(input int plen, input bit glitch,
                              output int first_hi, output int hi_n,
                              output int lo_busy_n, output int rises,
                              output int end_busy);
        int prev;
        first_hi = -1; hi_n = 0; lo_busy_n = 0; rises = 0; prev = 0;
        fault_n = 1'b0;
        for (int i = 1; i <= WIN; i++) begin
            @(negedge clk);
            if (flag) hi_n++;
            if (busy && !flag) lo_busy_n++;
            if (flag && !prev) begin
                rises++;
                if (first_hi < 0) first_hi = i;
            end
            prev = int'(flag);
            end_busy = int'(busy);
            fault_n = 1'b1;
            if (i < plen) fault_n = 1'b0;
            if (glitch && ((i >= 10 && i < 13) || (i >= 45 && i < 48))) fault_n = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int fh, hn, lb, rs, eb, gap, seen_fall;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset flag", int'(flag), 0);
        check("R8 reset busy", int'(busy), 0);
        rst = 1'b0;

        // R1 R6: idle with no fault
        eb = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (busy || flag) eb++;
        end
        check("R1 R6 idle stays quiet", eb, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            run_window(VEC_LEN[v], VEC_GL[v], fh, hn, lb, rs, eb);
            check($sformatf("R2 R1 start delay vec%0d", v), fh, 3);
            check($sformatf("R3 off length vec%0d", v), hn, HALF);
            check($sformatf("R4 on length vec%0d", v), lb, HALF - 1);
            check($sformatf("R5 single rise vec%0d", v), rs, 1);
            check($sformatf("R4 R6 idle at end vec%0d", v), eb, 0);
        end

        // R7: persistent fault retriggers after one idle cycle
        fault_n = 1'b0;
        gap = 0; seen_fall = 0; rs = 0; fh = 0;
        for (int i = 0; i < 3 * HALF + 10; i++) begin
            @(negedge clk);
            if (!seen_fall && fh && !busy) seen_fall = 1;
            if (busy) fh = 1;
            if (seen_fall == 1 && !busy) gap++;
            if (seen_fall == 1 && busy) begin
                seen_fall = 2;
                rs = int'(flag);
            end
        end
        check("R7 idle gap", gap, 1);
        check("R7 retrigger flag", rs, 1);

        // R8: reset mid-cycle
        @(negedge clk);
        check("R8 busy before reset", int'(busy), 1);
        fault_n = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid flag", int'(flag), 0);
        check("R8 mid busy", int'(busy), 0);
        rst = 1'b0;
        eb = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || flag) eb++;
        end
        check("R8 R6 idle after reset", eb, 0);

        // R9: flag implies busy over a full cycle
        fault_n = 1'b0;
        @(negedge clk);
        fault_n = 1'b1;
        eb = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (flag && !busy) eb++;
        end
        check("R9 flag without busy", eb, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule